// File: doc/BRIEF.md
# Oscillator Trim Tamer

This block steers a local voltage-controlled oscillator onto an external timing reference. The reference is either a once-per-second pulse or a 10 MHz clock. From it the block builds gates of nominally one second. It counts local clock cycles across each gate and turns the count into a signed frequency error. From that error it drives a 16-bit trim code toward the value that makes the error zero.

Enabling the block starts an acquisition phase. The trim is parked at its lowest code and the error is measured there. It is then parked at its highest code and measured again. A straight line through the two results gives the starting code. After that the block never stops tracking. It corrects at once on a large one-gate error. It corrects on a ten-gate sum when the error is moderate. Failing both, it corrects on a hundred-gate sum. Each step is scaled by the error and by the slope learned during acquisition.

The trim output is not a valid/ready stream. A new code is announced by a one-cycle strobe, and the downstream DAC driver must take it in that cycle, because there is no back-pressure. Mode and phase are plain control and status pins. A host selects the mode and reads the phase and the current trim code.

Top module: `ott_tamer`

## Requirements
- R1: After reset the trim code is 0x8000, the strobe is low and the phase reads 0 (idle).
- R2: The mode input has four encodings. 2'b01 is pulse mode, where a gate spans successive synchronised rising edges. 2'b10 is clock mode, where a gate spans REF_DIV rising edges. 2'b00 and 2'b11 are off. In an off mode the phase reads 0 one cycle later and the trim code is held with no strobe.
- R3: Leaving an off mode puts out trim code 0x0000 with a strobe and enters phase 1.
- R4: In phase 1 the next gate is dropped and the gate after it gives e_lo, which is the cycle count minus NOMINAL. The block then puts out 0xFFFF with a strobe and enters phase 2.
- R5: In phase 2 the block drops one gate and measures e_hi. If e_hi > e_lo, the start code is floor(-e_lo*65535/(e_hi-e_lo)): it is 0 when e_lo >= 0, it saturates at 0xFFFF, and the block then takes slope s = e_hi-e_lo. Otherwise the start code is 0x8000 and s = 1.
- R6: After every trim change, the first gate that completes is dropped and is not used.
- R7: In tracking, if the magnitude of the first gate's error exceeds THR_COARSE, a correction with window W=1 is made at once.
- R8: Otherwise, if the magnitude of the sum of the first ten errors exceeds THR_FINE, a correction with W=10 is made.
- R9: Otherwise a correction with W=100 is made on the sum of the first hundred errors. This happens even when that sum is zero, in which case the same code is put out again with a strobe.
- R10: A correction changes the trim by floor(|E|*65535/(s*W)) after that step is saturated to 0xFFFF. It moves down for a positive E and up otherwise, and the result is clamped to 0x0000..0xFFFF.
- R11: trim_stb is never high for two cycles in a row, and trim_code changes only in a cycle where trim_stb is high.
- R12: Once acquisition is done the phase reads 4 (tracking) or 5 (correction in progress), and the block keeps tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock, which is both the measured clock and the logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference pulse or reference clock, asynchronous to clk |
| mode | input | 2 | 01 pulse mode, 10 clock mode, 00 and 11 off |
| trim_code | output | 16 | Current trim DAC code |
| trim_stb | output | 1 | One-cycle strobe marking a new trim code |
| phase | output | 3 | 0 idle, 1 low probe, 2 high probe, 3 solving, 4 tracking, 5 correcting |

## Verification
Closing one gate and opening the next happen in the same clock cycle. The count that ends must be latched in that cycle while the counter restarts, so that no local cycle is lost or counted twice. The bench provokes this on every gate. It uses a reference model whose pulse spacing is an exact function of the trim code, and it also runs a clock-mode pass with a fixed 50-cycle reference period. Every code it expects, including the 0x8000 fallback that a pair of exactly-zero errors must produce, depends on cycle-exact counts, so any slip at the gate boundary shows up as a wrong trim value.

// File: rtl/ott_pkg.sv
package ott_pkg;

  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_PPS = 2'b01,
    MODE_TEN = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOW   = 3'd1,
    PH_HIGH  = 3'd2,
    PH_SOLVE = 3'd3,
    PH_TRACK = 3'd4,
    PH_FIX   = 3'd5
  } phase_e;

  localparam logic [15:0] TRIM_MAX = 16'hFFFF;
  localparam logic [15:0] TRIM_MID = 16'h8000;

endpackage

// File: rtl/ott_gate.sv
module ott_gate
  import ott_pkg::*;
#(
  parameter int REF_DIV     = 10_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_in,
  input  logic [1:0] mode,
  output logic       tick
);

  logic [SYNC_STAGES:0] shreg;
  logic                 rise;
  logic                 div_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], ref_in};
  end

  assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];

  generate
    if (REF_DIV > 1) begin : g_div
      localparam int DV_W = $clog2(REF_DIV + 1);
      logic [DV_W-1:0] edges;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    edges <= '0;
        else if (mode != MODE_TEN)     edges <= '0;
        else if (rise) begin
          if (edges == DV_W'(REF_DIV - 1)) edges <= '0;
          else                             edges <= edges + 1'b1;
        end
      end
      assign div_hit = rise && (edges == DV_W'(REF_DIV - 1));
    end else begin : g_nodiv
      assign div_hit = rise;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ((mode == MODE_PPS) && rise) || ((mode == MODE_TEN) && div_hit);
  end

endmodule

// File: rtl/ott_period.sv
module ott_period #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] meas,
  output logic             meas_vld
);

  logic [CNT_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= '0;
      meas     <= '0;
      meas_vld <= 1'b0;
    end else begin
      meas_vld <= tick;
      if (tick) begin
        meas <= run + 1'b1;
        run  <= '0;
      end else begin
        run  <= run + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ott_div.sv
module ott_div #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         done
);

  localparam int STEP_W = $clog2(W + 1);

  logic [W-1:0]      rem;
  logic [STEP_W-1:0] left;
  logic              busy;
  logic [W:0]        shifted;
  logic [W:0]        diff;
  logic              ge;

  always_comb begin
    shifted = {rem, quo[W-1]};
    diff    = shifted - {1'b0, den};
    ge      = ~diff[W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem  <= '0;
      quo  <= '0;
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        quo  <= num;
        left <= STEP_W'(W);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= ge ? diff[W-1:0] : shifted[W-1:0];
        quo  <= {quo[W-2:0], ge};
        left <= left - 1'b1;
        if (left == STEP_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ott_tamer.sv
module ott_tamer
  import ott_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int NOMINAL     = 38_400_000,
  parameter int REF_DIV     = 10_000_000,
  parameter int THR_COARSE  = 3840,
  parameter int THR_FINE    = 3840,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ref_in,
  input  logic [1:0]  mode,
  output logic [15:0] trim_code,
  output logic        trim_stb,
  output logic [2:0]  phase
);

  localparam int ERR_W = CNT_W + 8;
  localparam int DIV_W = ERR_W + 16;
  localparam int WIN_W = 7;

  logic                    gate_tick;
  logic [CNT_W-1:0]        meas;
  logic                    meas_vld;
  logic signed [ERR_W-1:0] err_now, acc, acc_nx, e_lo;
  logic [ERR_W-1:0]        span;
  logic [WIN_W-1:0]        n_win, n_nx;
  logic                    div_go, div_done, lower, skip, en;
  logic [DIV_W-1:0]        div_num, div_den, quo;
  phase_e                  st;

  ott_gate #(.REF_DIV(REF_DIV), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mode(mode), .tick(gate_tick));

  ott_period #(.CNT_W(CNT_W)) u_period (
    .clk(clk), .rst_n(rst_n), .tick(gate_tick), .meas(meas), .meas_vld(meas_vld));

  ott_div #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(div_num), .den(div_den),
    .quo(quo), .done(div_done));

  function automatic logic [ERR_W-1:0] mag(input logic signed [ERR_W-1:0] v);
    return v[ERR_W-1] ? ERR_W'(-v) : ERR_W'(v);
  endfunction

  function automatic logic [DIV_W-1:0] by_full(input logic [ERR_W-1:0] a);
    return {a, 16'h0000} - {16'h0000, a};
  endfunction

  function automatic logic [15:0] sat16(input logic [DIV_W-1:0] q);
    return (q > DIV_W'(TRIM_MAX)) ? TRIM_MAX : q[15:0];
  endfunction

  function automatic logic [15:0] step(input logic [15:0] t, input logic [15:0] d,
                                       input logic dn);
    logic [16:0] s;
    if (dn) begin
      s = {1'b0, t} - {1'b0, d};
      return s[16] ? 16'h0000 : s[15:0];
    end
    s = {1'b0, t} + {1'b0, d};
    return s[16] ? TRIM_MAX : s[15:0];
  endfunction

  assign en      = (mode == MODE_PPS) || (mode == MODE_TEN);
  assign err_now = $signed({{(ERR_W-CNT_W){1'b0}}, meas}) - $signed(ERR_W'(NOMINAL));
  assign acc_nx  = acc + err_now;
  assign n_nx    = n_win + 1'b1;
  assign phase   = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= PH_IDLE;
      trim_code <= TRIM_MID;
      trim_stb  <= 1'b0;
      skip      <= 1'b0;
      e_lo      <= '0;
      span      <= '0;
      acc       <= '0;
      n_win     <= '0;
      lower     <= 1'b0;
      div_go    <= 1'b0;
      div_num   <= '0;
      div_den   <= '0;
    end else begin
      trim_stb <= 1'b0;
      div_go   <= 1'b0;
      if (!en) begin
        st <= PH_IDLE;
      end else begin
        case (st)
          PH_IDLE: begin
            trim_code <= 16'h0000;
            trim_stb  <= 1'b1;
            skip      <= 1'b1;
            st        <= PH_LOW;
          end
          PH_LOW: if (meas_vld) begin
            if (skip) skip <= 1'b0;
            else begin
              e_lo      <= err_now;
              trim_code <= TRIM_MAX;
              trim_stb  <= 1'b1;
              skip      <= 1'b1;
              st        <= PH_HIGH;
            end
          end
          PH_HIGH: if (meas_vld) begin
            if (skip) skip <= 1'b0;
            else if (err_now <= e_lo) begin
              span      <= ERR_W'(1);
              trim_code <= TRIM_MID;
              trim_stb  <= 1'b1;
              skip      <= 1'b1;
              acc       <= '0;
              n_win     <= '0;
              st        <= PH_TRACK;
            end else begin
              span    <= ERR_W'(err_now - e_lo);
              div_num <= e_lo[ERR_W-1] ? by_full(mag(e_lo)) : '0;
              div_den <= DIV_W'(ERR_W'(err_now - e_lo));
              div_go  <= 1'b1;
              st      <= PH_SOLVE;
            end
          end
          PH_SOLVE: if (div_done) begin
            trim_code <= sat16(quo);
            trim_stb  <= 1'b1;
            skip      <= 1'b1;
            acc       <= '0;
            n_win     <= '0;
            st        <= PH_TRACK;
          end
          PH_TRACK: if (meas_vld) begin
            if (skip) skip <= 1'b0;
            else if ((n_nx == WIN_W'(1) && mag(acc_nx) > ERR_W'(THR_COARSE)) ||
                     (n_nx == WIN_W'(10) && mag(acc_nx) > ERR_W'(THR_FINE)) ||
                     (n_nx == WIN_W'(100))) begin
              div_num <= by_full(mag(acc_nx));
              div_den <= DIV_W'(span) * ((n_nx == WIN_W'(1))  ? DIV_W'(1)  :
                                         (n_nx == WIN_W'(10)) ? DIV_W'(10) : DIV_W'(100));
              lower   <= ~acc_nx[ERR_W-1];
              div_go  <= 1'b1;
              st      <= PH_FIX;
            end else begin
              acc   <= acc_nx;
              n_win <= n_nx;
            end
          end
          PH_FIX: if (div_done) begin
            trim_code <= step(trim_code, sat16(quo), lower);
            trim_stb  <= 1'b1;
            skip      <= 1'b1;
            acc       <= '0;
            n_win     <= '0;
            st        <= PH_TRACK;
          end
          default: st <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ott_tamer_chk.sv
module ott_tamer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  mode,
  input logic [15:0] trim_code,
  input logic        trim_stb,
  input logic [2:0]  phase
);

  // R11
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trim_stb |=> !trim_stb);

  // R11
  trim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trim_stb |-> $stable(trim_code));

  // R2
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |=> (phase == 3'd0));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd0) |-> !trim_stb);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1 && $past(phase) == 3'd0) |-> (trim_stb && trim_code == 16'h0000));

  // R12
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase) >= 3'd4 && phase != 3'd0) |-> (phase == 3'd4 || phase == 3'd5));

endmodule

bind ott_tamer ott_tamer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .trim_code(trim_code),
  .trim_stb(trim_stb), .phase(phase));

// File: tb/ott_tamer_test.sv
`timescale 1ns/1ps
module ott_tamer_test;

  localparam int CW    = 16;
  localparam int NOM   = 200;
  localparam int DIV   = 4;
  localparam int THR_C = 8;
  localparam int THR_F = 16;
  localparam int BASE  = 150;

  // {drift[15:0], expected code[15:0], tag[3:0]}
  localparam logic [35:0] VEC [8] = '{
    {16'd0,      16'h0000,  4'd3},
    {16'd0,      16'hFFFF,  4'd4},
    {16'd0,      16'd52011, 4'd5},
    {16'd20,     16'd31207, 4'd7},
    {16'd23,     16'd28087, 4'd8},
    {16'd24,     16'd27047, 4'd9},
    {16'd24,     16'd27047, 4'd9},
    {16'hFFC4,   16'hFFFF,  4'd10}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_in;
  logic [1:0]  mode;
  logic [15:0] trim_code;
  logic        trim_stb;
  logic [2:0]  phase;

  int checks = 0;
  int fails = 0;
  int stb_seen = 0;
  int drift = 0;
  bit pps_on = 0;
  bit ten_on = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ott_tamer #(.CNT_W(CW), .NOMINAL(NOM), .REF_DIV(DIV), .THR_COARSE(THR_C),
              .THR_FINE(THR_F)) uut (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .mode(mode),
    .trim_code(trim_code), .trim_stb(trim_stb), .phase(phase));

  function automatic string tag_name(input int t);
    case (t)
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb(output logic [15:0] code, output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!trim_stb && gap < 60000);
    if (!trim_stb) check(1'b0, "R11 strobe timeout", gap, 0);
    code = trim_code;
  endtask

  // oscillator model: reference spacing in local cycles follows the trim code
  initial begin
    int n;
    ref_in = 1'b0;
    forever begin
      @(posedge clk);
      if (pps_on) begin
        n = BASE + int'(trim_code >> 10) + drift;
        ref_in <= 1'b1;
        @(posedge clk);
        @(posedge clk);
        ref_in <= 1'b0;
        repeat (n - 3) @(posedge clk);
      end else if (ten_on) begin
        repeat (24) @(posedge clk);
        ref_in <= ~ref_in;
      end
    end
  end

  always @(negedge clk) if (rst_n === 1'b1 && trim_stb) stb_seen++;

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] code;
    int gap;
    int s0;
    rst_n = 1'b0;
    mode  = 2'b00;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(trim_code == 16'h8000, "R1 trim", trim_code, 16'h8000);
    check(trim_stb == 1'b0, "R1 strobe", trim_stb, 0);
    check(phase == 3'd0, "R1 phase", phase, 0);

    // R2: encoding 11 is off, reference running
    pps_on = 1;
    mode = 2'b11;
    repeat (500) @(negedge clk);
    check(stb_seen == 0, "R2 mode 11 strobes", stb_seen, 0);
    check(phase == 3'd0, "R2 mode 11 phase", phase, 0);

    // vector table: acquisition then tracking in pulse mode
    mode = 2'b01;
    for (int i = 0; i < 8; i++) begin
      drift = int'($signed(VEC[i][35:20]));
      wait_stb(code, gap);
      check(code == VEC[i][19:4], tag_name(int'(VEC[i][3:0])), code, VEC[i][19:4]);
      if (i == 1) check(gap > 150, "R6 gate discarded", gap, 151);
      if (i == 2) begin
        @(negedge clk);
        check(trim_stb == 1'b0, "R11 strobe width", trim_stb, 0);
        check(phase == 3'd4, "R12 tracking", phase, 4);
      end
    end

    // R2: disabling holds the code and idles
    mode = 2'b00;
    @(negedge clk);
    check(phase == 3'd0, "R2 off phase", phase, 0);
    s0 = stb_seen;
    repeat (1500) @(negedge clk);
    check(stb_seen == s0, "R2 off strobes", stb_seen - s0, 0);
    check(trim_code == 16'hFFFF, "R2 off hold", trim_code, 16'hFFFF);

    // clock mode: both probes give zero error -> mid-scale fallback
    pps_on = 0;
    repeat (300) @(negedge clk);
    ten_on = 1;
    repeat (200) @(negedge clk);
    mode = 2'b10;
    wait_stb(code, gap);
    check(code == 16'h0000, "R3 clock mode low probe", code, 0);
    wait_stb(code, gap);
    check(code == 16'hFFFF, "R4 clock mode high probe", code, 16'hFFFF);
    wait_stb(code, gap);
    check(code == 16'h8000, "R5 flat slope fallback", code, 16'h8000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule